// File: doc/BRIEF.md
# Leveled Interrupt Pending and Priority Controller

This block records pending interrupt sources in a set of priority levels. Every level owns a vector of source bits, and a status word with one bit per level shows which levels currently hold at least one source. Requesters post or clear a single source by giving its level and its index within that level. A clear-all strobe empties everything in one cycle.

On an evaluate strobe, the block forms a winning priority and a summary mask. The winning priority combines the software request bits presented on a separate input with the external levels held in the status word. It signals a take when that priority is non-zero, strictly above the current threshold, and the program counter's low bits show an aligned instruction. A take loads the winner into holding registers. A later update strobe moves the held values onto the interrupt-ID and interrupt-summary outputs.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A post of index k at level L with both in range sets bit k of level L's vector and sets status bit L on the next clock edge.
- R2: A clear of index k at level L clears that bit. Status bit L drops only if no other bit of level L remains set.
- R3: A clear-all strobe empties every level vector and drives the status word to zero on the next clock edge.
- R4: `int_pending` is high exactly when the status word is non-zero and `pc_low` equals 2'b00.
- R5: Each set `sw_req` bit i with SW_LO <= i < SW_HI yields candidate priority i - SW_LO + 1 and sets bit i of the summary mask. The highest such bit gives the software priority.
- R6: Each set status bit i with EXT_LO <= i < EXT_HI sets bit i of the summary mask. If any such bit is set, the priority is the highest such i, and it overrides any software priority. The mask always includes both groups.
- R7: `take` is high only when `eval` is high, `pc_low` is 2'b00, and the priority is non-zero and strictly greater than `thresh`.
- R8: A take loads the priority and mask into holding registers and marks them valid. An update while they are valid copies them to `iid` and `isum` on the next edge and clears the valid mark. If a take occurs in the same cycle as an update, the take's values become the new valid content.
- R9: A post or clear with level >= NLVL or index >= SRC_W changes no state and raises `err` for one cycle.
- R10: An update while no held value is valid raises `err` for one cycle and leaves `iid` and `isum` unchanged.
- R11: When strobes coincide, clear-all wins over clear, and clear wins over post. Only the winning command acts.
- R12: A synchronous reset clears all vectors, the status word, the holding registers, `iid`, `isum` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| post_en | input | 1 | Post the source selected by `lvl`/`idx` |
| clr_en | input | 1 | Clear the source selected by `lvl`/`idx` |
| clr_all | input | 1 | Empty all levels |
| lvl | input | LW | Level of the post or clear |
| idx | input | IW | Source index within the level |
| sw_req | input | NLVL | Software request bits |
| pc_low | input | 2 | Low two bits of the current program counter |
| thresh | input | PW | Current priority threshold |
| eval | input | 1 | Request a priority decision this cycle |
| upd | input | 1 | Publish the held decision |
| status | output | NLVL | Per-level non-empty status |
| int_pending | output | 1 | Something pending at an aligned address |
| take | output | 1 | Interrupt taken this cycle |
| iid | output | PW | Published interrupt priority |
| isum | output | NLVL | Published summary mask |
| err | output | 1 | One-cycle error pulse |

## Verification
The hardest situation to reach from the ports is a take decided by software requests alone, with the status word empty so that `int_pending` is low. A close second is an update that coincides with a fresh take. In that case the published values and the valid mark must come from two different decisions. Directed steps drive `sw_req` with all levels empty and issue `eval` and `upd` in one cycle. A long random phase then mixes coinciding strobes, out-of-range indices and misaligned `pc_low` values. A behavioural model checks every output after every edge.

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
  parameter int NLVL   = 8,
  parameter int SRC_W  = 16,
  parameter int SW_LO  = 1,
  parameter int SW_HI  = 4,
  parameter int EXT_LO = 4,
  parameter int EXT_HI = 8,
  parameter int LW     = $clog2(NLVL) + 1,
  parameter int IW     = $clog2(SRC_W) + 1,
  parameter int PW     = $clog2(NLVL) + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            post_en,
  input  logic            clr_en,
  input  logic            clr_all,
  input  logic [LW-1:0]   lvl,
  input  logic [IW-1:0]   idx,
  input  logic [NLVL-1:0] sw_req,
  input  logic [1:0]      pc_low,
  input  logic [PW-1:0]   thresh,
  input  logic            eval,
  input  logic            upd,
  output logic [NLVL-1:0] status,
  output logic            int_pending,
  output logic            take,
  output logic [PW-1:0]   iid,
  output logic [NLVL-1:0] isum,
  output logic            err
);
  localparam int LI = LW - 1;
  localparam int II = IW - 1;

  logic [SRC_W-1:0] vec [NLVL];
  logic [PW-1:0]    win, held_pri;
  logic [NLVL-1:0]  msk, held_msk;
  logic             held_vld;

  wire              in_rng = (lvl < LW'(NLVL)) && (idx < IW'(SRC_W));
  wire [LI-1:0]     li     = lvl[LI-1:0];
  wire [SRC_W-1:0]  kbit   = SRC_W'(1) << idx[II-1:0];
  wire              aligned = (pc_low == 2'b00);

  always_comb begin
    win = '0;
    msk = '0;
    for (int i = SW_LO; i < SW_HI; i++)
      if (sw_req[i]) begin
        win    = PW'(i - SW_LO + 1);
        msk[i] = 1'b1;
      end
    for (int i = EXT_LO; i < EXT_HI; i++)
      if (status[i]) begin
        win    = PW'(i);
        msk[i] = 1'b1;
      end
  end

  assign int_pending = (|status) && aligned;
  assign take        = eval && aligned && (win != '0) && (win > thresh);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NLVL; l++) vec[l] <= '0;
      status   <= '0;
      held_pri <= '0;
      held_msk <= '0;
      held_vld <= 1'b0;
      iid      <= '0;
      isum     <= '0;
      err      <= 1'b0;
    end else begin
      err <= 1'b0;
      if (clr_all) begin
        for (int l = 0; l < NLVL; l++) vec[l] <= '0;
        status <= '0;
      end else if (clr_en) begin
        if (!in_rng) err <= 1'b1;
        else begin
          vec[li] <= vec[li] & ~kbit;
          if ((vec[li] & ~kbit) == '0) status[li] <= 1'b0;
        end
      end else if (post_en) begin
        if (!in_rng) err <= 1'b1;
        else begin
          vec[li]    <= vec[li] | kbit;
          status[li] <= 1'b1;
        end
      end
      if (upd) begin
        if (held_vld) begin
          iid      <= held_pri;
          isum     <= held_msk;
          held_vld <= 1'b0;
        end else err <= 1'b1;
      end
      if (take) begin
        held_pri <= win;
        held_msk <= msk;
        held_vld <= 1'b1;
      end
    end
  end

  p_post_sets_r1: assert property (@(posedge clk) disable iff (rst)
    (post_en && !clr_en && !clr_all && in_rng) |=> status[$past(li)]);

  p_clear_all_r3: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (status == '0));

  p_take_holds_r8: assert property (@(posedge clk) disable iff (rst)
    take |=> held_vld && (held_pri == $past(win)));

  p_oor_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    ((post_en || clr_en) && !clr_all && !in_rng) |=> err && $stable(status));

  p_upd_empty_r10: assert property (@(posedge clk) disable iff (rst)
    (upd && !held_vld) |=> err && $stable(iid) && $stable(isum));

  p_status_tracks_r2: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !clr_all && in_rng && ((vec[li] & ~kbit) != '0)) |=> status[$past(li)]);
endmodule

// File: tb/tb_lvl_irq_ctrl.sv
module tb_lvl_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NLVL = 8, SRC_W = 16, SW_LO = 1, SW_HI = 4, EXT_LO = 4, EXT_HI = 8;

  logic clk = 0, rst = 1;
  logic post_en = 0, clr_en = 0, clr_all = 0, eval = 0, upd = 0;
  logic [3:0] lvl = 0;
  logic [4:0] idx = 0;
  logic [7:0] sw_req = 0;
  logic [1:0] pc_low = 0;
  logic [3:0] thresh = 0;
  logic [7:0] status, isum;
  logic int_pending, take, err;
  logic [3:0] iid;

  lvl_irq_ctrl dut (.clk(clk), .rst(rst), .post_en(post_en), .clr_en(clr_en),
    .clr_all(clr_all), .lvl(lvl), .idx(idx), .sw_req(sw_req), .pc_low(pc_low),
    .thresh(thresh), .eval(eval), .upd(upd), .status(status),
    .int_pending(int_pending), .take(take), .iid(iid), .isum(isum), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] mv [8];
  int m_iid, m_isum, m_hp, m_hm;
  bit m_hv, m_err;

  function automatic int m_status();
    int s = 0;
    for (int l = 0; l < NLVL; l++) if (mv[l] != 0) s |= (1 << l);
    return s;
  endfunction

  function automatic void m_decide(output int pri, output int mask);
    int s = m_status();
    pri = 0; mask = 0;
    for (int i = SW_LO; i < SW_HI; i++) if (sw_req[i]) mask |= (1 << i);
    for (int i = EXT_LO; i < EXT_HI; i++) if (s[i]) mask |= (1 << i);
    for (int i = EXT_HI - 1; i >= EXT_LO && pri == 0; i--) if (s[i]) pri = i;
    for (int i = SW_HI - 1; i >= SW_LO && pri == 0; i--) if (sw_req[i]) pri = i - SW_LO + 1;
  endfunction

  function automatic bit m_take();
    int p, m;
    m_decide(p, m);
    return eval && pc_low == 0 && p != 0 && p > int'(thresh);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int s = m_status();
    chk(status == s[7:0], "R1/R2/R3/R11 status", int'(status), s);
    chk(int_pending == (s != 0 && pc_low == 0), "R4 int_pending", int'(int_pending), int'(s != 0 && pc_low == 0));
    chk(take == m_take(), "R5/R6/R7 take", int'(take), int'(m_take()));
    chk(err == m_err, "R9/R10 err", int'(err), int'(m_err));
    chk(iid == m_iid[3:0], "R5/R6/R8 iid", int'(iid), m_iid);
    chk(isum == m_isum[7:0], "R5/R6/R8 isum", int'(isum), m_isum);
  endtask

  task automatic m_update();
    bit oor = (lvl >= NLVL) || (idx >= SRC_W);
    bit tk = m_take();
    int p, m;
    m_decide(p, m);
    m_err = 0;
    if (rst) begin
      for (int l = 0; l < NLVL; l++) mv[l] = 0;
      m_iid = 0; m_isum = 0; m_hp = 0; m_hm = 0; m_hv = 0;
      return;
    end
    if (clr_all) for (int l = 0; l < NLVL; l++) mv[l] = 0;
    else if (clr_en) begin if (oor) m_err = 1; else mv[lvl][idx] = 1'b0; end
    else if (post_en) begin if (oor) m_err = 1; else mv[lvl][idx] = 1'b1; end
    if (upd) begin
      if (m_hv) begin m_iid = m_hp; m_isum = m_hm; m_hv = 0; end
      else m_err = 1;
    end
    if (tk) begin m_hp = p; m_hm = m; m_hv = 1; end
  endtask

  task automatic cyc();
    #1;
    compare();
    @(posedge clk);
    m_update();
    @(negedge clk);
  endtask

  task automatic idle();
    post_en = 0; clr_en = 0; clr_all = 0; eval = 0; upd = 0;
  endtask

  task automatic op_post(int l, int k); idle(); post_en = 1; lvl = 4'(l); idx = 5'(k); cyc(); idle(); endtask
  task automatic op_clr(int l, int k);  idle(); clr_en = 1;  lvl = 4'(l); idx = 5'(k); cyc(); idle(); endtask
  task automatic op_eval(int th);       idle(); eval = 1; thresh = 4'(th); cyc(); idle(); endtask
  task automatic op_upd();              idle(); upd = 1; cyc(); idle(); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_err = 0;
    @(negedge clk);
    rst = 1; cyc(); cyc();
    rst = 0;
    cyc(); // R12 reset state compared
    // R1 post
    op_post(5, 3); op_post(5, 9); cyc();
    // R6/R7/R8 external take then publish
    op_eval(0); op_upd(); cyc();
    // R2 partial then full clear
    op_clr(5, 3); cyc(); op_clr(5, 9); cyc();
    // R5 software only, status empty
    sw_req = 8'b0000_1100;
    op_eval(2); op_upd(); cyc();
    op_eval(3); cyc();                 // R7 strict compare: no take
    pc_low = 2'b10; op_eval(0); cyc(); // R7 misaligned
    pc_low = 2'b00;
    // R6 external overrides software, mask union
    op_post(4, 0); op_eval(1); op_upd(); cyc();
    // R10 update without valid
    op_upd(); cyc();
    // R9 out of range
    op_post(9, 1); op_post(2, 20); op_clr(8, 0); cyc();
    // R8 take and update together
    op_eval(0);
    idle(); eval = 1; upd = 1; thresh = 0; post_en = 1; lvl = 7; idx = 15; cyc(); idle();
    idle(); eval = 1; upd = 1; cyc(); idle();
    op_upd(); cyc();
    // R11 priority among strobes
    idle(); clr_en = 1; post_en = 1; lvl = 3; idx = 2; cyc(); idle();
    op_post(3, 2);
    idle(); clr_all = 1; post_en = 1; lvl = 6; idx = 1; cyc(); idle();
    // R3 clear-all
    op_post(1, 1); op_post(6, 6); idle(); clr_all = 1; cyc(); idle(); cyc();
    sw_req = 0;
    // random phase
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      idle();
      post_en = (r < 35);
      clr_en  = (r >= 30 && r < 55);
      clr_all = (r == 99);
      lvl     = 4'($urandom_range(0, 9));
      idx     = 5'($urandom_range(0, 17));
      eval    = ($urandom_range(0, 3) == 0);
      upd     = ($urandom_range(0, 3) == 0);
      thresh  = 4'($urandom_range(0, 8));
      pc_low  = ($urandom_range(0, 4) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
      if ($urandom_range(0, 15) == 0) sw_req = 8'($urandom);
      cyc();
    end
    idle();
    cyc();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule